// File: doc/BRIEF.md
# Audio Master Clock Divider

This block produces a codec master clock from an oversampling timebase. The timebase runs at either 512 or 384 times the audio sample rate, and a base-select input states which one is in use. A 3-bit multiplier code selects a power-of-two divide of that timebase, so the master clock can be set anywhere from 32x to 512x the sample rate. The block also passes on the timebase as a one-cycle base tick for a serial bit-clock generator, and it reports which base is currently applied.

The timebase comes in as a clock enable, `os_tick`, in the fast system clock domain. Each tick marks one half period of the oversampling clock, so a tick that arrives on every clock cycle means the oversampling clock runs at half the system clock rate. The master clock is a registered level output with a 50% duty cycle. It starts on `run` and stops when `run` is dropped. A new divide setting takes effect only where the output falls, so the output never carries a shortened pulse. A separate `gate` input forces the output low at once.

Top module: `amclk_divider`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it rises, `mclk`, `base_tick` and `base_384` are 0. The reset is synchronous and active low.
- R2: One asserted `os_tick` is one half period of the oversampling clock. When `os_tick` is low and `gate` is low, `mclk` keeps its level across the clock edge, whatever `run`, `base_sel` and `mult_code` do.
- R3: With `base_sel`=0 (512x base), `mult_code` values 0, 1, 2, 3 and 4 give high and low phases of 1, 2, 4, 8 and 16 ticks. That is a master clock of 512, 256, 128, 64 and 32 times fs.
- R4: With `base_sel`=1 (384x base), `mult_code` values 0, 1, 2 and 3 give phases of 1, 2, 4 and 8 ticks. That is a master clock of 384, 192, 96 and 48 times fs.
- R5: A code above the limit for the selected base is treated as that limit. Codes 5 to 7 with the 512x base act as code 4. Codes 4 to 7 with the 384x base act as code 3.
- R6: While running, every high phase of `mclk` lasts exactly as long as every low phase (50% duty).
- R7: From the stopped state, the first tick seen with `run`=1 starts the divider with `mclk` low. The first rising edge comes after a full low phase of 2^code ticks.
- R8: Dropping `run` while `mclk` is high lets the current high phase run to its full length. `mclk` then falls and stays low.
- R9: A change of `mult_code` or `base_sel` while running is applied only on the tick where `mclk` falls. The high phase in progress keeps its old length, and the next low phase uses the new length.
- R10: `gate`=1 drives `mclk` low on the next clock edge and keeps it low, whatever the other inputs do. After `gate` drops, the divider restarts as in R7.
- R11: While the divider is running, `base_tick` is `os_tick` delayed by one clock. While it is stopped or gated, `base_tick` stays 0. `base_384` shows the base that was last applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| os_tick | input | 1 | Half-period enable of the oversampling timebase |
| base_sel | input | 1 | Oversampling base: 0 = 512x fs, 1 = 384x fs |
| mult_code | input | 3 | Power-of-two divide code |
| run | input | 1 | Master clock enable, applied at a low phase |
| gate | input | 1 | Immediate force-low of the master clock |
| mclk | output | 1 | Codec master clock, 50% duty |
| base_tick | output | 1 | Registered timebase tick for the bit-clock generator |
| base_384 | output | 1 | Base applied to the divider (1 = 384x) |

## Verification
A table covers every legal code on both bases, plus the out-of-range codes on each. Each entry starts the divider from the stopped state and measures the first low stretch, a high phase and the next low phase. This separates wrong divide ratios from a wrong saturation limit, a lost start phase or a skewed duty cycle. One entry uses a tick on every third... rather, every second cycle, so a divider that counts clocks instead of ticks gives the wrong length. Directed tests then change the code partway through a high phase, drop `run` while the output is high, remove the ticks entirely, and assert `gate` in the middle of a phase. These show whether settings are applied at the falling edge, as R9 and R8 require, or at once.

// File: rtl/amclk_pkg.sv
// Shared types and helpers for the audio master clock divider.
// Assumes a single synchronous clock domain for all users.
package amclk_pkg;

    // Oversampling base of the incoming timebase.
    typedef enum logic {
        BASE_512 = 1'b0,
        BASE_384 = 1'b1
    } base_e;

    // Largest legal divide code for a given base.
    function automatic int code_limit(base_e b, int lim512, int lim384);
        return (b == BASE_384) ? lim384 : lim512;
    endfunction

endpackage

// File: rtl/amclk_code_sat.sv
// Clamps the requested divide code to the largest code that is legal
// for the requested base. Purely combinational; no state.
// Assumes LIM_384 <= LIM_512 < 2**CODE_W.
module amclk_code_sat
    import amclk_pkg::*;
#(
    parameter int CODE_W  = 3,
    parameter int LIM_512 = 4,
    parameter int LIM_384 = 3
) (
    input  logic [CODE_W-1:0] code_in,
    input  base_e             base_in,
    output logic [CODE_W-1:0] code_out
);

    localparam logic [CODE_W-1:0] L512 = CODE_W'(LIM_512);
    localparam logic [CODE_W-1:0] L384 = CODE_W'(LIM_384);

    logic [CODE_W-1:0] lim;

    // Select the clamp limit and saturate the code against it.
    always_comb begin
        lim      = (base_in == BASE_384) ? L384 : L512;
        code_out = (code_in > lim) ? lim : code_in;
    end

endmodule

// File: rtl/amclk_div_core.sv
// Power-of-two tick divider with glitch-free reconfiguration.
// Counts os_tick pulses and toggles the output every 2**code ticks.
// Settings and run are sampled only on the tick where the output falls,
// or on any tick while stopped. gate is a synchronous hard stop.
// Assumes req_code is already clamped to the limit of req_base.
module amclk_div_core
    import amclk_pkg::*;
#(
    parameter int CODE_W  = 3,
    parameter int LIM_512 = 4,
    parameter int LIM_384 = 3,
    parameter int CNT_W   = LIM_512 + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              os_tick,
    input  logic              gate,
    input  logic              run,
    input  logic [CODE_W-1:0] req_code,
    input  base_e             req_base,
    output logic              mclk_q,
    output logic              act_on,
    output base_e             act_base
);

    logic [CODE_W-1:0] act_code;
    logic [CNT_W-1:0]  cnt;
    logic [CNT_W-1:0]  lim;
    logic              wrap;

    // Last count value of a half period for the applied code.
    always_comb begin
        lim  = (CNT_W'(1) << act_code) - CNT_W'(1);
        wrap = (cnt == lim);
    end

    // Divider state: counter, output level and applied settings.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_on   <= 1'b0;
            act_code <= '0;
            act_base <= BASE_512;
            cnt      <= '0;
            mclk_q   <= 1'b0;
        end else if (gate) begin
            act_on   <= 1'b0;
            act_code <= req_code;
            act_base <= req_base;
            cnt      <= '0;
            mclk_q   <= 1'b0;
        end else if (os_tick) begin
            if (!act_on) begin
                act_code <= req_code;
                act_base <= req_base;
                cnt      <= '0;
                act_on   <= run;
            end else if (wrap) begin
                cnt <= '0;
                if (mclk_q) begin
                    mclk_q   <= 1'b0;
                    act_code <= req_code;
                    act_base <= req_base;
                    act_on   <= run;
                end else begin
                    mclk_q <= 1'b1;
                end
            end else begin
                cnt <= cnt + CNT_W'(1);
            end
        end
    end

    // R2
    mclk_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!os_tick && !gate) |=> $stable(mclk_q));

    // R10
    gate_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        gate |=> !mclk_q);

    // R8
    idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !act_on |-> !mclk_q);

    // R9
    code_apply_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(act_code) |-> !mclk_q);

    // R5
    code_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int'(act_code) <= code_limit(act_base, LIM_512, LIM_384));

    // R6
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= lim);

endmodule

// File: rtl/amclk_base_out.sv
// Registers the timebase tick for the downstream bit-clock generator.
// The tick is passed on only while the divider is running and not gated.
module amclk_base_out (
    input  logic clk,
    input  logic rst_n,
    input  logic os_tick,
    input  logic act_on,
    input  logic gate,
    output logic base_tick
);

    // One-cycle delayed, qualified copy of the timebase tick.
    always_ff @(posedge clk) begin
        if (!rst_n) base_tick <= 1'b0;
        else        base_tick <= os_tick & act_on & ~gate;
    end

    // R11
    tick_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(act_on) |-> !base_tick);

endmodule

// File: rtl/amclk_divider.sv
// Audio master clock divider top. Clamps the divide code for the chosen
// base, divides the oversampling tick stream by 2**code into a 50% duty
// master clock, and forwards the base tick. All logic runs on clk.
module amclk_divider
    import amclk_pkg::*;
#(
    parameter int CODE_W  = 3,
    parameter int LIM_512 = 4,
    parameter int LIM_384 = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              os_tick,
    input  logic              base_sel,
    input  logic [CODE_W-1:0] mult_code,
    input  logic              run,
    input  logic              gate,
    output logic              mclk,
    output logic              base_tick,
    output logic              base_384
);

    localparam int CNT_W = LIM_512 + 1;

    base_e             req_base;
    base_e             act_base;
    logic [CODE_W-1:0] eff_code;
    logic              act_on;

    assign req_base = base_e'(base_sel);
    assign base_384 = (act_base == BASE_384);

    amclk_code_sat #(
        .CODE_W (CODE_W),
        .LIM_512(LIM_512),
        .LIM_384(LIM_384)
    ) i_sat (
        .code_in (mult_code),
        .base_in (req_base),
        .code_out(eff_code)
    );

    amclk_div_core #(
        .CODE_W (CODE_W),
        .LIM_512(LIM_512),
        .LIM_384(LIM_384),
        .CNT_W  (CNT_W)
    ) i_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .os_tick (os_tick),
        .gate    (gate),
        .run     (run),
        .req_code(eff_code),
        .req_base(req_base),
        .mclk_q  (mclk),
        .act_on  (act_on),
        .act_base(act_base)
    );

    amclk_base_out i_bout (
        .clk      (clk),
        .rst_n    (rst_n),
        .os_tick  (os_tick),
        .act_on   (act_on),
        .gate     (gate),
        .base_tick(base_tick)
    );

    // R11
    tick_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        base_tick |-> $past(os_tick));

endmodule

// File: tb/test_amclk_divider.sv
module test_amclk_divider;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       os_tick = 1'b0;
    logic       base_sel;
    logic [2:0] mult_code;
    logic       run;
    logic       gate;
    logic       mclk;
    logic       base_tick;
    logic       base_384;

    int total = 0;
    int bad   = 0;
    int tick_per = 1;
    bit done = 1'b0;

    always #5 clk = ~clk;

    amclk_divider i_amclk_divider (
        .clk      (clk),
        .rst_n    (rst_n),
        .os_tick  (os_tick),
        .base_sel (base_sel),
        .mult_code(mult_code),
        .run      (run),
        .gate     (gate),
        .mclk     (mclk),
        .base_tick(base_tick),
        .base_384 (base_384)
    );

    // Vector: base[8], code[7:5], expected half period in ticks [4:0]
    localparam int NV = 13;
    localparam logic [8:0] VEC [NV] = '{
        {1'b0, 3'd0, 5'd1},  {1'b0, 3'd1, 5'd2},  {1'b0, 3'd2, 5'd4},
        {1'b0, 3'd3, 5'd8},  {1'b0, 3'd4, 5'd16}, {1'b0, 3'd6, 5'd16},
        {1'b0, 3'd7, 5'd16}, {1'b1, 3'd0, 5'd1},  {1'b1, 3'd1, 5'd2},
        {1'b1, 3'd2, 5'd4},  {1'b1, 3'd3, 5'd8},  {1'b1, 3'd4, 5'd8},
        {1'b1, 3'd7, 5'd8}
    };

    // Tick generator: drives os_tick just after each rising edge.
    initial begin
        int tc = 0;
        forever begin
            @(posedge clk);
            #1;
            if (tick_per <= 0) begin
                os_tick = 1'b0;
            end else begin
                tc = (tc + 1) % tick_per;
                os_tick = (tc == 0);
            end
        end
    end

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Count consecutive negedge samples at which mclk equals lvl.
    task automatic run_len(input logic lvl, output int n);
        n = 0;
        while (mclk === lvl && n < 2000) begin
            n++;
            @(negedge clk);
        end
    endtask

    // Hard stop through gate, then load settings and run from stopped.
    task automatic start_cfg(input logic b, input logic [2:0] c);
        gate = 1'b1;
        @(negedge clk);
        gate      = 1'b0;
        base_sel  = b;
        mult_code = c;
        run       = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        int first, hi, lo, n;
        rst_n = 1'b0; base_sel = 1'b0; mult_code = '0; run = 1'b0; gate = 1'b0;
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 mclk", int'(mclk), 0);
        check("R1 base_tick", int'(base_tick), 0);
        check("R1 base_384", int'(base_384), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 mclk after release", int'(mclk), 0);

        // Table walk: R3, R4, R5, R6, R7, R11
        for (int i = 0; i < NV; i++) begin
            logic       vb;
            logic [2:0] vc;
            int         vn;
            string      tag;
            vb = VEC[i][8];
            vc = VEC[i][7:5];
            vn = int'(VEC[i][4:0]);
            tag = (vb ? ((vc > 3'd3) ? "R5" : "R4") : ((vc > 3'd4) ? "R5" : "R3"));
            start_cfg(vb, vc);
            run_len(1'b0, first);
            run_len(1'b1, hi);
            run_len(1'b0, lo);
            check({tag, " half period"}, hi, vn);
            check("R6 duty", lo, hi);
            check("R7 first low phase", first, vn);
            check("R11 base_384", int'(base_384), int'(vb));
        end

        // R4 with a tick on every second cycle: phases count ticks
        tick_per = 2;
        start_cfg(1'b1, 3'd2);
        run_len(1'b0, first);
        run_len(1'b1, hi);
        check("R4 tick-scaled half period", hi, 8);

        // R11 base_tick follows os_tick by one cycle while running
        tick_per = 3;
        repeat (4) @(negedge clk);
        for (int k = 0; k < 9; k++) begin
            logic prev;
            prev = os_tick;
            @(negedge clk);
            check("R11 base_tick", int'(base_tick), int'(prev));
        end
        tick_per = 1;

        // R9 code change during high phase applies at the fall
        start_cfg(1'b0, 3'd3);
        run_len(1'b0, first);
        mult_code = 3'd1;
        run_len(1'b1, hi);
        run_len(1'b0, lo);
        check("R9 old high kept", hi, 8);
        check("R9 new low", lo, 2);
        run_len(1'b1, hi);
        check("R9 new high", hi, 2);

        // R2 no ticks: mclk holds its level
        start_cfg(1'b0, 3'd2);
        run_len(1'b0, first);
        tick_per = 0;
        n = 0;
        for (int k = 0; k < 30; k++) begin
            @(negedge clk);
            if (mclk !== 1'b1) n++;
        end
        check("R2 level held without ticks", n, 0);
        tick_per = 1;

        // R8 stop during high phase completes the phase then stays low
        start_cfg(1'b0, 3'd2);
        run_len(1'b0, first);
        @(negedge clk);
        run = 1'b0;
        run_len(1'b1, hi);
        check("R8 high phase completed", hi + 1, 4);
        n = 0;
        for (int k = 0; k < 40; k++) begin
            @(negedge clk);
            if (mclk !== 1'b0 || base_tick !== 1'b0) n++;
        end
        check("R8 held low after stop", n, 0);

        // R10 gate forces low at once, then restart from stopped
        start_cfg(1'b0, 3'd3);
        run_len(1'b0, first);
        repeat (2) @(negedge clk);
        gate = 1'b1;
        @(negedge clk);
        check("R10 low after gate", int'(mclk), 0);
        n = 0;
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            if (mclk !== 1'b0 || base_tick !== 1'b0) n++;
        end
        check("R10 held low while gated", n, 0);
        gate = 1'b0;
        @(negedge clk);
        run_len(1'b0, first);
        check("R10 restart low phase", first, 8);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule